// File: doc/BRIEF.md
# Feedback ADC Control Sequencer

This block is the digital half of a feedback analog-to-digital converter. It drives a code into an external DAC and reads one comparator bit that says whether the DAC output is above the analog input. From that bit it searches for the input level. Three search methods share a single datapath: a ramp that counts up from zero, a tracker that moves one LSB per step toward the input, and a successive-approximation search that settles one bit per step.

A conversion begins with a one-clock `start_i` pulse. The method is taken from `mode_i` on that same clock. After each code change the block waits `SETTLE_CLKS` clocks so the analog path can settle, and only then reads the comparator. In ramp and successive-approximation modes it finishes by loading the result register and pulsing `done_o`. In tracking mode it keeps running for as long as `track_en_i` stays high and rewrites the result after every step.

Top module: `fbadc_ctrl`

## Requirements
- R1: After reset `dac_code_o`, `result_o`, `busy_o` and `done_o` are all zero.
- R2: Ramp mode (mode 00) clears the code to zero on start and adds one per step until the comparator reports above. The result is the last code that was not above, which is the code minus one, or zero if code zero was already above. If the all-ones code is still not above, the result is all ones.
- R3: A ramp conversion lasts (steps × SETTLE_CLKS) clocks of `busy_o`. An input level v in LSB (0 ≤ v < 2^N−1) takes v+2 steps, and a full-scale input takes 2^N steps.
- R4: Successive-approximation mode (mode 10) sets the first trial code to the MSB alone.
- R5: In successive approximation, a trial bit is cleared when the comparator reports above and is kept otherwise, and then the next lower bit is set. After exactly N steps the result equals the input level clamped to the code range.
- R6: Tracking mode (mode 01) raises the code by one when the comparator reports not above and lowers it by one when it reports above, once per step. After each step `result_o` holds the code that was just compared.
- R7: In tracking mode the code saturates at zero and at all ones and never wraps.
- R8: Tracking stops one clock after `track_en_i` goes low. `busy_o` falls and the code and result then hold. `done_o` never pulses in tracking mode.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the running conversion.
- R10: `done_o` is high for exactly one clock, on the clock where the result loads in ramp or successive-approximation mode, and `busy_o` is low on that clock.
- R11: `mode_i` is sampled only when a conversion is accepted. Changes during a conversion do not alter the method, the latency or the result.
- R12: Each step holds the code unchanged for SETTLE_CLKS clocks before the comparator is sampled, so a successive-approximation conversion occupies N × SETTLE_CLKS clocks of `busy_o`.
- R13: Mode value 11 behaves as ramp mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when idle |
| mode_i | input | 2 | Method: 00 ramp, 01 tracking, 10 successive approximation, 11 ramp |
| track_en_i | input | 1 | Keeps tracking mode running while high |
| above_i | input | 1 | Comparator: 1 when the DAC output is above the analog input |
| dac_code_o | output | WIDTH | Code driven to the DAC |
| busy_o | output | 1 | A conversion or tracking run is in progress |
| done_o | output | 1 | One-clock pulse when a ramp or successive-approximation result loads |
| result_o | output | WIDTH | Converted word |

## Verification
The assertions take for granted that `above_i` depends only on the DAC code and the analog level, and that it is already valid when the settle window ends. They also assume `start_i` and `mode_i` are synchronous to the clock. The bench models the comparator as an ideal combinational compare of the code against an integer input level, so it always answers within the settle window. All inputs are driven on the falling edge. Input levels of −1 and above full scale are used only to force one comparator answer permanently, which exercises the saturation limits.

// File: rtl/fbadc_pkg.sv
package fbadc_pkg;
    typedef enum logic [1:0] {
        MODE_RAMP     = 2'b00,
        MODE_TRACK    = 2'b01,
        MODE_SAR      = 2'b10,
        MODE_RAMP_ALT = 2'b11
    } adc_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } adc_state_e;
endpackage

// File: rtl/fbadc_settle_timer.sv
module fbadc_settle_timer #(
    parameter int SETTLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CLKS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fbadc_code_step.sv
module fbadc_code_step
    import fbadc_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  adc_mode_e        mode_i,
    input  logic [WIDTH-1:0] code_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             above_i,
    output logic [WIDTH-1:0] code_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             finish_o,
    output logic [WIDTH-1:0] sample_o
);
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
    localparam logic [WIDTH-1:0] ALL_ONE = '1;
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [WIDTH-1:0] trial;

    always_comb begin
        code_o   = code_i;
        idx_o    = idx_i;
        finish_o = 1'b0;
        sample_o = code_i;
        trial    = code_i;
        case (mode_i)
            MODE_TRACK: begin
                if (above_i) begin
                    if (code_i != '0) code_o = code_i - ONE;
                end else if (code_i != ALL_ONE) begin
                    code_o = code_i + ONE;
                end
            end
            MODE_SAR: begin
                if (above_i) trial[idx_i] = 1'b0;
                sample_o = trial;
                code_o   = trial;
                if (idx_i == '0) begin
                    finish_o = 1'b1;
                end else begin
                    idx_o = idx_i - IDX_ONE;
                    code_o[idx_i - IDX_ONE] = 1'b1;
                end
            end
            default: begin
                if (above_i) begin
                    finish_o = 1'b1;
                    sample_o = (code_i == '0) ? '0 : (code_i - ONE);
                end else if (code_i == ALL_ONE) begin
                    finish_o = 1'b1;
                end else begin
                    code_o = code_i + ONE;
                end
            end
        endcase
    end
endmodule

// File: rtl/fbadc_ctrl.sv
module fbadc_ctrl
    import fbadc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SETTLE_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             track_en_i,
    input  logic             above_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(WIDTH - 1);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        adc_state_e       state;
        adc_mode_e        mode;
        logic [WIDTH-1:0] code;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] result;
        logic             done;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic             step_tick;
    logic [WIDTH-1:0] nxt_code;
    logic [IDX_W-1:0] nxt_idx;
    logic             nxt_finish;
    logic [WIDTH-1:0] nxt_sample;
    logic [1:0]       cur_mode;

    fbadc_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.state == ST_RUN),
        .tick_o (step_tick)
    );

    fbadc_code_step #(.WIDTH(WIDTH)) u_step (
        .mode_i   (r_q.mode),
        .code_i   (r_q.code),
        .idx_i    (r_q.idx),
        .above_i  (above_i),
        .code_o   (nxt_code),
        .idx_o    (nxt_idx),
        .finish_o (nxt_finish),
        .sample_o (nxt_sample)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_RUN;
                    r_d.mode  = adc_mode_e'(mode_i);
                    r_d.idx   = TOP_IDX;
                    case (adc_mode_e'(mode_i))
                        MODE_SAR:   r_d.code = MSB_ONLY;
                        MODE_TRACK: r_d.code = r_q.code;
                        default:    r_d.code = '0;
                    endcase
                end
            end
            default: begin
                if (r_q.mode == MODE_TRACK && !track_en_i) begin
                    r_d.state = ST_IDLE;
                end else if (step_tick) begin
                    r_d.code = nxt_code;
                    r_d.idx  = nxt_idx;
                    if (r_q.mode == MODE_TRACK) begin
                        r_d.result = nxt_sample;
                    end
                    if (nxt_finish) begin
                        r_d.result = nxt_sample;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, mode: MODE_RAMP, code: '0, idx: '0, result: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_mode   = r_q.mode;
    assign dac_code_o = r_q.code;
    assign busy_o     = (r_q.state == ST_RUN);
    assign done_o     = r_q.done;
    assign result_o   = r_q.result;
endmodule

// File: rtl/fbadc_ctrl_checker.sv
module fbadc_ctrl_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       mode_i,
    input logic             track_en_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] dac_code_o,
    input logic [WIDTH-1:0] result_o,
    input logic             step_tick,
    input logic [1:0]       cur_mode
);
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_ramp_begin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> (dac_code_o == '0));

    p_sar_begin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && mode_i == 2'b10) |=> (dac_code_o == MSB_ONLY));

    p_track_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cur_mode == 2'b01 && track_en_i && step_tick) |=>
        (dac_code_o == $past(dac_code_o) + ONE || dac_code_o == $past(dac_code_o) - ONE
         || dac_code_o == $past(dac_code_o)));

    p_code_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_tick && !(start_i && !busy_o)) |=> $stable(dac_code_o));

    p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy_o) |=> $stable(cur_mode));

    p_result_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(result_o) && cur_mode != 2'b01) |-> done_o);

    p_no_done_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cur_mode != 2'b01));
endmodule

bind fbadc_ctrl fbadc_ctrl_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .track_en_i (track_en_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dac_code_o (dac_code_o),
    .result_o   (result_o),
    .step_tick  (step_tick),
    .cur_mode   (cur_mode)
);

// File: tb/fbadc_ctrl_test.sv
module fbadc_ctrl_test;
    localparam int N    = 6;
    localparam int S    = 3;
    localparam int FULL = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode_in = 2'b00;
    logic         track_en = 1'b0;
    logic         above;
    logic [N-1:0] code;
    logic         busy;
    logic         done;
    logic [N-1:0] result;
    int           vin = 0;
    int           checks = 0;
    int           errors = 0;
    bit           done_seen = 1'b0;

    always #10 clk = ~clk;

    always_comb above = (int'(code) > vin);

    fbadc_ctrl #(.WIDTH(N), .SETTLE_CLKS(S)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .mode_i     (mode_in),
        .track_en_i (track_en),
        .above_i    (above),
        .dac_code_o (code),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v < 0) return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    function automatic int ramp_steps(input int v);
        if (v < 0) return 1;
        if (v >= FULL) return FULL + 1;
        return v + 2;
    endfunction

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) done_seen = 1'b1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; track_en = 1'b0; mode_in = 2'b00;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic run_conv(input int md, input int v, input bit glitch,
                            output int res, output int cyc, output int first, output bit pulse_ok);
        vin = v;
        @(negedge clk);
        mode_in = 2'(md); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first = int'(code);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (glitch && cyc == 2) begin
                start = 1'b1; mode_in = 2'b01; track_en = 1'b0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        pulse_ok = done;
        res = int'(result);
        @(negedge clk);
        pulse_ok = pulse_ok && !done;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "code after reset", int'(code), 0);
        chk("R1", "result after reset", int'(result), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
    endtask

    task automatic t_ramp();
        int levels[4] = '{0, 21, 62, 63};
        int res, cyc, first; bit ok;
        foreach (levels[k]) begin
            run_conv(0, levels[k], 1'b0, res, cyc, first, ok);
            chk("R2", "ramp first code", first, 0);
            chk("R2", "ramp result", res, clampv(levels[k]));
            chk("R3", "ramp busy cycles", cyc, ramp_steps(levels[k]) * S);
            chk("R10", "ramp done single pulse", int'(ok), 1);
        end
    endtask

    task automatic t_ramp_alt();
        int res, cyc, first; bit ok;
        run_conv(3, 9, 1'b0, res, cyc, first, ok);
        chk("R13", "mode 11 result", res, 9);
        chk("R13", "mode 11 busy cycles", cyc, ramp_steps(9) * S);
    endtask

    task automatic t_sar();
        int levels[5] = '{0, 63, 42, 17, 100};
        int res, cyc, first; bit ok;
        foreach (levels[k]) begin
            run_conv(2, levels[k], 1'b0, res, cyc, first, ok);
            chk("R4", "sar first trial", first, 1 << (N - 1));
            chk("R5", "sar result", res, clampv(levels[k]));
            chk("R12", "sar busy cycles", cyc, N * S);
            chk("R10", "sar done single pulse", int'(ok), 1);
        end
    endtask

    task automatic t_busy_start();
        int res, cyc, first; bit ok;
        run_conv(2, 50, 1'b1, res, cyc, first, ok);
        chk("R9", "result with start while busy", res, 50);
        chk("R11", "latency with mode change", cyc, N * S);
        chk("R11", "done despite mode change", int'(ok), 1);
        mode_in = 2'b00;
    endtask

    task automatic t_track();
        do_reset();
        done_seen = 1'b0;
        vin = 10; track_en = 1'b1;
        @(negedge clk);
        mode_in = 2'b01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc(5 * S);
        chk("R6", "track code after 5 steps", int'(code), 5);
        chk("R6", "track result after 5 steps", int'(result), 4);
        wait_cyc(30 * S);
        chk("R6", "track code after 35 steps", int'(code), 11);
        chk("R6", "track result after 35 steps", int'(result), 10);
        vin = 1000;
        wait_cyc((FULL + 5) * S);
        chk("R7", "track upper clamp", int'(code), FULL);
        wait_cyc(S);
        chk("R7", "track upper clamp held", int'(code), FULL);
        vin = -1;
        wait_cyc((FULL + 5) * S);
        chk("R7", "track lower clamp", int'(code), 0);
        wait_cyc(S);
        chk("R7", "track lower clamp held", int'(code), 0);
        chk("R7", "track result at lower clamp", int'(result), 0);
    endtask

    task automatic t_track_stop();
        int held_code, held_res;
        vin = 30;
        wait_cyc(4 * S + 1);
        track_en = 1'b0;
        wait_cyc(1);
        chk("R8", "busy after track disable", int'(busy), 0);
        held_code = int'(code);
        held_res = int'(result);
        vin = 60;
        wait_cyc(20);
        chk("R8", "code held after stop", int'(code), held_code);
        chk("R8", "result held after stop", int'(result), held_res);
        chk("R8", "no done in tracking", int'(done_seen), 0);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_ramp_alt();
        t_sar();
        t_busy_start();
        t_track();
        t_track_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule